// File: doc/BRIEF.md
# External Bus Turnaround Idle Inserter

This block sequences external memory bus cycles one state per clock. A read runs for three states and a write for two. When a write is accepted in the very last state of a read, the block can place one quiet state in front of the write. In that state neither strobe is active and the data-bus driver is off. A slow device that is still releasing the data bus after the read then has a clear state to let go before new write data appears.

Requests arrive one at a time on a valid/ready handshake that carries the direction, the address and the write data. A configuration input, `idle_en`, switches the quiet-state insertion on or off. It is sampled when the write is accepted. A second input, `int_access`, marks a request that follows an internal access: the preceding read no longer counts as adjacent to it. The block drives the address, the active-low read and write strobes, the data output and its enable. It also returns the captured read data together with a one-cycle completion pulse.

Top module: `bus_turnaround_seq`

## Requirements
- R1: A read occupies exactly three consecutive clock states with `bus_rd_n` low, `bus_wr_n` high and `bus_oe` low. `bus_din` is captured in the third state. `done` is high for exactly one cycle in the following cycle, with `rdata` holding the captured value.
- R2: A write occupies exactly two consecutive clock states with `bus_oe` high and `bus_dout` equal to the write data. `bus_wr_n` is low only in the second of them. `done` is high for exactly one cycle in the following cycle. The two strobes are never low together.
- R3: A write accepted in the final state of a read, with `idle_en` = 1 and `int_access` = 0 at acceptance, is preceded by exactly one state in which `bus_rd_n` = 1, `bus_wr_n` = 1, `bus_oe` = 0 and `req_ready` = 0. Its first active state follows that state.
- R4: With `idle_en` = 0 at acceptance, a write accepted in the final state of a read starts its first active state in the very next clock.
- R5: Read after read, write after write and read after write, each accepted in the final state of the earlier cycle, run with no quiet state between them.
- R6: The read history is cleared when the write is not accepted in the read's final state, meaning at least one bus state without a request lies between them, or when `int_access` = 1 at acceptance. A write that follows a read in either way is not preceded by a quiet state.
- R7: `idle_en` is used only at the moment a request is accepted. Changing it while a cycle or its quiet state is running does not change that cycle.
- R8: After reset: `bus_rd_n` = 1, `bus_wr_n` = 1, `bus_oe` = 0, `done` = 0, `req_ready` = 1.
- R9: `req_ready` is high only when no cycle is running or in the final state of a cycle. It is low in the quiet state and in every non-final state of a cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| idle_en | input | 1 | Enables the quiet state on read-to-write turnaround |
| int_access | input | 1 | The request follows an internal access; clears the read history |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Data captured by the last read |
| bus_addr | output | ADDR_W | External address |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_oe | output | 1 | Data-bus output enable |
| bus_dout | output | DATA_W | Data driven onto the bus |
| bus_din | input | DATA_W | Data read from the bus |

## Verification
The assertions assume that a requester keeps `req_write`, `req_addr` and `req_wdata` steady while `req_valid` waits for `req_ready`. They also assume that `int_access` and `idle_en` matter only in the cycle of acceptance. The bench changes its inputs only on falling edges and holds every field until the acceptance edge. It sweeps every pairing of read and write, both enable values, gaps of zero to two free states, and both values of the internal-access flag. Around each acceptance it drives the opposite `idle_en` value, so that sampling at the wrong moment shows up as a wrong gap.

// File: rtl/bts_pkg.sv
package bts_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_TI   = 3'd1,
    ST_T1   = 3'd2,
    ST_T2   = 3'd3,
    ST_T3   = 3'd4
  } bus_st_e;
endpackage

// File: rtl/bts_gap.sv
module bts_gap
  import bts_pkg::*;
(
  input  bus_st_e st_q,
  input  logic    wr_q,
  input  logic    accept,
  input  logic    req_write,
  input  logic    idle_en,
  input  logic    int_access,
  output logic    insert
);
  logic rd_finishing;

  always_comb begin
    // a read is finishing only in its third state
    rd_finishing = (st_q == ST_T3) && !wr_q;
    insert       = accept && req_write && idle_en && !int_access && rd_finishing;
  end
endmodule

// File: rtl/bts_seq.sv
module bts_seq
  import bts_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              idle_en,
  input  logic              int_access,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output bus_st_e           st_q,
  output bus_st_e           st_d,
  output logic              wr_q,
  output logic              wr_d,
  output logic [ADDR_W-1:0] addr_d,
  output logic [DATA_W-1:0] wdata_d
);
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              accept;
  logic              insert;

  assign req_ready = (st_q == ST_IDLE) || (st_q == ST_T3) || ((st_q == ST_T2) && wr_q);
  assign accept    = req_valid && req_ready;

  bts_gap u_gap (
    .st_q       (st_q),
    .wr_q       (wr_q),
    .accept     (accept),
    .req_write  (req_write),
    .idle_en    (idle_en),
    .int_access (int_access),
    .insert     (insert)
  );

  always_comb begin
    st_d    = st_q;
    wr_d    = wr_q;
    addr_d  = addr_q;
    wdata_d = wdata_q;
    if (accept) begin
      st_d    = insert ? ST_TI : ST_T1;
      wr_d    = req_write;
      addr_d  = req_addr;
      wdata_d = req_wdata;
    end else begin
      unique case (st_q)
        ST_TI:   st_d = ST_T1;
        ST_T1:   st_d = ST_T2;
        ST_T2:   st_d = wr_q ? ST_IDLE : ST_T3;
        ST_T3:   st_d = ST_IDLE;
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      st_q    <= st_d;
      wr_q    <= wr_d;
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
    end
  end

  // R3
  ti_follows_read_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_T3 && req_valid && req_write && idle_en && !int_access) |=> (st_q == ST_TI));
  // R3
  ti_single_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_TI) |=> (st_q == ST_T1));
  // R4
  no_ti_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !idle_en) |=> (st_q != ST_TI));
  // R6
  ti_only_after_read_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && st_q != ST_T3) |=> (st_q != ST_TI));
  // R9
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_TI || st_q == ST_T1) |-> !req_ready);
  // R1
  read_len_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_T2 && !wr_q) |=> (st_q == ST_T3));
endmodule

// File: rtl/bts_pins.sv
module bts_pins
  import bts_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  bus_st_e           st_q,
  input  bus_st_e           st_d,
  input  logic              wr_q,
  input  logic              wr_d,
  input  logic [ADDR_W-1:0] addr_d,
  input  logic [DATA_W-1:0] wdata_d,
  input  logic [DATA_W-1:0] bus_din,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_rd_n,
  output logic              bus_wr_n,
  output logic              bus_oe,
  output logic [DATA_W-1:0] bus_dout
);
  logic nx_active;
  logic nx_rd;
  logic nx_wr_drive;
  logic nx_wr_strobe;

  always_comb begin
    nx_active    = (st_d == ST_T1) || (st_d == ST_T2) || (st_d == ST_T3);
    nx_rd        = nx_active && !wr_d;
    nx_wr_drive  = wr_d && ((st_d == ST_T1) || (st_d == ST_T2));
    nx_wr_strobe = wr_d && (st_d == ST_T2);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_addr <= '0;
      bus_rd_n <= 1'b1;
      bus_wr_n <= 1'b1;
      bus_oe   <= 1'b0;
      bus_dout <= '0;
      rdata    <= '0;
      done     <= 1'b0;
    end else begin
      if (nx_active)   bus_addr <= addr_d;
      if (nx_wr_drive) bus_dout <= wdata_d;
      bus_rd_n <= !nx_rd;
      bus_wr_n <= !nx_wr_strobe;
      bus_oe   <= nx_wr_drive;
      if (st_q == ST_T3) rdata <= bus_din;
      done <= (st_q == ST_T3) || ((st_q == ST_T2) && wr_q);
    end
  end

  // R3
  ti_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_TI) |-> (bus_rd_n && bus_wr_n && !bus_oe));
  // R2
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_rd_n |-> (bus_wr_n && !bus_oe));
  // R2
  wr_inside_oe_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_wr_n |-> bus_oe);
  // R1
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/bus_turnaround_seq.sv
module bus_turnaround_seq
  import bts_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              idle_en,
  input  logic              int_access,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_rd_n,
  output logic              bus_wr_n,
  output logic              bus_oe,
  output logic [DATA_W-1:0] bus_dout,
  input  logic [DATA_W-1:0] bus_din
);
  bus_st_e           st_q;
  bus_st_e           st_d;
  logic              wr_q;
  logic              wr_d;
  logic [ADDR_W-1:0] addr_d;
  logic [DATA_W-1:0] wdata_d;

  bts_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .idle_en    (idle_en),
    .int_access (int_access),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .req_ready  (req_ready),
    .st_q       (st_q),
    .st_d       (st_d),
    .wr_q       (wr_q),
    .wr_d       (wr_d),
    .addr_d     (addr_d),
    .wdata_d    (wdata_d)
  );

  bts_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk      (clk),
    .rst      (rst),
    .st_q     (st_q),
    .st_d     (st_d),
    .wr_q     (wr_q),
    .wr_d     (wr_d),
    .addr_d   (addr_d),
    .wdata_d  (wdata_d),
    .bus_din  (bus_din),
    .done     (done),
    .rdata    (rdata),
    .bus_addr (bus_addr),
    .bus_rd_n (bus_rd_n),
    .bus_wr_n (bus_wr_n),
    .bus_oe   (bus_oe),
    .bus_dout (bus_dout)
  );
endmodule

// File: tb/tb_bus_turnaround_seq.sv
`timescale 1ns/1ps
module tb_bus_turnaround_seq;
  localparam int AW = 16;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          idle_en = 1'b0;
  logic          int_access = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          done;
  logic [DW-1:0] rdata;
  logic [AW-1:0] bus_addr;
  logic          bus_rd_n, bus_wr_n, bus_oe;
  logic [DW-1:0] bus_dout;
  logic [DW-1:0] bus_din;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  assign bus_din = bus_addr[DW-1:0] ^ 8'hA5;

  bus_turnaround_seq #(.ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rst(rst), .idle_en(idle_en), .int_access(int_access),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .done(done), .rdata(rdata),
    .bus_addr(bus_addr), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
    .bus_oe(bus_oe), .bus_dout(bus_dout), .bus_din(bus_din)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor state
  logic          mon_en = 1'b0;
  logic          act;
  int            act_cnt, gap, pend, ti_cnt, done_cnt, wrlow;
  bit            seen;
  logic          e_wr [2];
  logic [AW-1:0] e_addr [2];
  logic [DW-1:0] e_dat [2];

  always @(negedge clk) begin
    if (mon_en) begin
      act = !bus_rd_n || bus_oe;
      if (act) begin
        if (seen) gap += pend;
        pend = 0;
        act_cnt++;
        seen = 1;
      end else if (seen) begin
        pend++;
      end
      if (!act && !req_ready) ti_cnt++;
      if (!bus_wr_n && done_cnt < 2) begin
        wrlow++;
        // R2 data and address during the strobe
        chk(bus_dout == e_dat[done_cnt], "R2 write data", int'(bus_dout), int'(e_dat[done_cnt]));
        chk(bus_addr == e_addr[done_cnt], "R2 write addr", int'(bus_addr), int'(e_addr[done_cnt]));
      end
      if (done) begin
        if (done_cnt < 2 && !e_wr[done_cnt])
          // R1 captured read data
          chk(rdata == (e_addr[done_cnt][DW-1:0] ^ 8'hA5), "R1 read data",
              int'(rdata), int'(e_addr[done_cnt][DW-1:0] ^ 8'hA5));
        done_cnt++;
      end
    end
  end

  task automatic run_pair(input bit w1, input bit w2, input bit en, input int d,
                          input bit ia, input int n);
    int l1, l2, ins;
    l1 = w1 ? 2 : 3;
    l2 = w2 ? 2 : 3;
    ins = (en && !w1 && w2 && d == 0 && !ia) ? 1 : 0;
    e_wr[0] = w1;  e_addr[0] = AW'(16'h1000 + n * 7);  e_dat[0] = DW'(n * 3 + 1);
    e_wr[1] = w2;  e_addr[1] = AW'(16'h2000 + n * 11); e_dat[1] = DW'(n * 5 + 2);
    repeat (4) @(negedge clk);
    act_cnt = 0; gap = 0; pend = 0; ti_cnt = 0; done_cnt = 0; wrlow = 0; seen = 0;
    mon_en = 1'b1;
    // first request; enable held at the opposite value (R7)
    req_valid = 1'b1; req_write = w1; req_addr = e_addr[0]; req_wdata = e_dat[0];
    idle_en = !en; int_access = 1'b0;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (l1 - 1 + d) @(negedge clk);
    req_valid = 1'b1; req_write = w2; req_addr = e_addr[1]; req_wdata = e_dat[1];
    idle_en = en; int_access = ia;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; int_access = 1'b0; idle_en = !en;
    repeat (7) @(negedge clk);
    mon_en = 1'b0;
    // R3 R4 R5 R6 R7 quiet-state count between the two cycles
    chk(gap == d + ins, $sformatf("R3/R4/R5/R6/R7 gap w1=%0d w2=%0d en=%0d d=%0d ia=%0d", w1, w2, en, d, ia),
        gap, d + ins);
    // R9 not-ready quiet states
    chk(ti_cnt == ins, "R9 quiet not-ready count", ti_cnt, ins);
    // R1 R2 active state count
    chk(act_cnt == l1 + l2, "R1/R2 active states", act_cnt, l1 + l2);
    chk(done_cnt == 2, "R1/R2 done pulses", done_cnt, 2);
    chk(wrlow == int'(w1) + int'(w2), "R2 write strobe states", wrlow, int'(w1) + int'(w2));
  endtask

  initial begin
    #(5.0 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8 reset state
    chk(bus_rd_n == 1'b1, "R8 rd_n", int'(bus_rd_n), 1);
    chk(bus_wr_n == 1'b1, "R8 wr_n", int'(bus_wr_n), 1);
    chk(bus_oe == 1'b0, "R8 oe", int'(bus_oe), 0);
    chk(done == 1'b0, "R8 done", int'(done), 0);
    chk(req_ready == 1'b1, "R8 ready", int'(req_ready), 1);
    for (int a = 0; a < 2; a++)
      for (int b = 0; b < 2; b++)
        for (int e = 0; e < 2; e++)
          for (int d = 0; d < 3; d++)
            for (int ia = 0; ia < 2; ia++) begin
              run_pair(a[0], b[0], e[0], d, ia[0], n);
              n++;
            end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule